// File: doc/BRIEF.md
# Serial Converter Port Controller

This block is the digital side of a 10-bit, 11-input successive-approximation converter that a host reaches over a serial port. The host pulls a select line low and toggles a serial clock. On the first four rising clock edges it sends a channel number, most significant bit first. On each falling edge it reads one bit of the result of the previous conversion, starting with the MSB. Analog parts are not part of the block. A behavioural stand-in computes a value from the channel number after a fixed number of system clocks.

All serial pins are oversampled by the system clock through two-flop synchronizers. Edges are detected on the synchronized copies, so the serial clock must run at least four times slower than the system clock. A transfer controller steps through five named states: `ST_IDLE`, `ST_ADDR`, `ST_SAMPLE`, `ST_TAIL` and `ST_HOLD`.
- ST_IDLE goes to ST_ADDR when select falls.
- ST_ADDR goes to ST_SAMPLE on the fourth falling edge.
- ST_SAMPLE goes to ST_TAIL on the tenth falling edge, which also starts the conversion.
- ST_TAIL goes to ST_HOLD on the sixteenth falling edge.
- Every active state returns to ST_IDLE when select rises.

Top module: `sadc_front`

## Requirements
- R1: While `cs_n` is high, `dout_oe` is 0 (output in high impedance), `sample_en` is 0, and `io_clk`/`addr_in` activity has no effect: no conversion starts and `eoc` stays 1.
- R2: After `cs_n` falls, `dout_oe` is 1 and `dout` shows bit 9 (MSB) of the last completed result. The result is 0 after reset.
- R3: The channel number is taken from `addr_in` on rising edges 1 to 4, MSB first. `chan_sel` holds the full 4-bit value after the fourth rising edge, and later `addr_in` values do not change it.
- R4: After falling edge k, for k = 1 to 9, `dout` shows result bit 9-k, so the LSB appears after the ninth falling edge.
- R5: From the tenth falling edge onward, `dout` is 0 for as long as select stays low.
- R6: `sample_en` is 1 from the fourth falling edge until the tenth falling edge, and 0 at all other times.
- R7: On the tenth falling edge `eoc` goes to 0. It returns to 1 after 20 system clocks, when the new result becomes available. The new result is {chan[3:0], 2'b10, ~chan[3:0]}.
- R8: If select rises before the tenth falling edge, no conversion starts. `eoc` stays 1 and the stored result is unchanged.
- R9: Serial clock edges after the sixteenth are ignored until select is released and asserted again: no further conversion starts and `dout` stays 0.
- R10: After reset, `eoc` is 1, `dout_oe` is 0 and `sample_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| io_clk | input | 1 | Serial clock from the host |
| addr_in | input | 1 | Serial channel number, MSB first |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | 1 when `dout` is driven, 0 for high impedance |
| eoc | output | 1 | 0 while a conversion is in progress |
| sample_en | output | 1 | Sampling window towards the analog front end |
| chan_sel | output | 4 | Channel number towards the multiplexer |

## Verification
Two situations are hard to reach from the ports: the counter region past the sixteenth clock, and a transfer cut off before its tenth clock. A design that wraps its counter would only show the error after another ten edges, as a second drop of `eoc`. The stimulus therefore sends random transfers whose lengths cover 10 to 16 clocks, some directed transfers of 20 to 28 clocks, and early releases after 3 to 9 clocks. Every transfer reads back the result left by the previous one, so a lost or corrupted conversion appears on the next `dout` stream.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SAMPLE,
        ST_TAIL,
        ST_HOLD
    } xfer_state_t;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int        WIDTH     = 1,
    parameter int        STAGES    = 2,
    parameter bit [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift,
    input  logic [RES_BITS-1:0] load_val,
    output logic                bit_out
);
    logic [RES_BITS-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= load_val;
        else if (shift) sh_q <= {sh_q[RES_BITS-2:0], 1'b0};
    end

    assign bit_out = sh_q[RES_BITS-1];
endmodule

// File: rtl/sadc_conv_stub.sv
module sadc_conv_stub #(
    parameter int RES_BITS    = 10,
    parameter int ADDR_BITS   = 4,
    parameter int CONV_CYCLES = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_BITS-1:0] chan,
    output logic                 busy,
    output logic [RES_BITS-1:0]  result
);
    localparam int CW     = $clog2(CONV_CYCLES + 1);
    localparam int FILL_W = RES_BITS - 2 * ADDR_BITS;

    logic [CW-1:0]        remain_q;
    logic [ADDR_BITS-1:0] chan_q;
    logic                 busy_q;
    logic [RES_BITS-1:0]  result_q;
    logic [RES_BITS-1:0]  code;

    always_comb begin
        code = '0;
        code[RES_BITS-1 -: ADDR_BITS] = chan_q;
        code[ADDR_BITS-1:0]           = ~chan_q;
        if (FILL_W > 0) code[ADDR_BITS + FILL_W - 1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            chan_q   <= '0;
            busy_q   <= 1'b0;
            result_q <= '0;
        end else if (start) begin
            remain_q <= CW'(CONV_CYCLES - 1);
            chan_q   <= chan;
            busy_q   <= 1'b1;
        end else if (busy_q) begin
            if (remain_q == '0) begin
                busy_q   <= 1'b0;
                result_q <= code;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    assign busy   = busy_q;
    assign result = result_q;
endmodule

// File: rtl/sadc_front.sv
module sadc_front
    import sadc_pkg::*;
#(
    parameter int RES_BITS    = 10,
    parameter int ADDR_BITS   = 4,
    parameter int MAX_CLKS    = 16,
    parameter int CONV_CYCLES = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 io_clk,
    input  logic                 addr_in,
    output logic                 dout,
    output logic                 dout_oe,
    output logic                 eoc,
    output logic                 sample_en,
    output logic [ADDR_BITS-1:0] chan_sel
);
    localparam int CNT_W   = $clog2(MAX_CLKS + 1);
    localparam int RISE_W  = $clog2(ADDR_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_ADDR_FALL = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_SAMP_FALL = CNT_W'(RES_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_FALL      = CNT_W'(MAX_CLKS - 1);

    // synchronized pins: {cs, clk, addr}
    logic [2:0] pins_s;
    logic       cs_s, sclk_s, addr_s;
    logic       cs_q, sclk_q;

    sadc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, io_clk, addr_in}),
        .q     (pins_s)
    );

    assign cs_s   = pins_s[2];
    assign sclk_s = pins_s[1];
    assign addr_s = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
        end
    end

    logic cs_fall, sclk_rise, sclk_fall;
    assign cs_fall   = cs_q & ~cs_s;
    assign sclk_rise = ~sclk_q & sclk_s & ~cs_s;
    assign sclk_fall = sclk_q & ~sclk_s & ~cs_s;

    xfer_state_t          state, state_nxt;
    logic [CNT_W-1:0]     fall_cnt;
    logic [RISE_W-1:0]    rise_cnt;
    logic [ADDR_BITS-1:0] addr_sh;
    logic                 conv_start;
    logic                 conv_busy;
    logic [RES_BITS-1:0]  conv_result;
    logic                 sh_load, sh_shift;

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cs_fall) state_nxt = ST_ADDR;
            end
            ST_ADDR: begin
                if (cs_s) state_nxt = ST_IDLE;
                else if (sclk_fall && fall_cnt == LAST_ADDR_FALL) state_nxt = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (cs_s) state_nxt = ST_IDLE;
                else if (sclk_fall && fall_cnt == LAST_SAMP_FALL) state_nxt = ST_TAIL;
            end
            ST_TAIL: begin
                if (cs_s) state_nxt = ST_IDLE;
                else if (sclk_fall && fall_cnt == LAST_FALL) state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (cs_s) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // edge counters and address capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_cnt <= '0;
            rise_cnt <= '0;
            addr_sh  <= '0;
            chan_sel <= '0;
        end else if (cs_fall) begin
            fall_cnt <= '0;
            rise_cnt <= '0;
        end else begin
            if (sclk_fall && state != ST_IDLE && state != ST_HOLD)
                fall_cnt <= fall_cnt + 1'b1;
            if (sclk_rise && state == ST_ADDR && rise_cnt < RISE_W'(ADDR_BITS)) begin
                rise_cnt <= rise_cnt + 1'b1;
                addr_sh  <= {addr_sh[ADDR_BITS-2:0], addr_s};
                if (rise_cnt == RISE_W'(ADDR_BITS - 1))
                    chan_sel <= {addr_sh[ADDR_BITS-2:0], addr_s};
            end
        end
    end

    // outputs derived from the state
    always_comb begin
        sample_en  = 1'b0;
        dout_oe    = 1'b1;
        conv_start = 1'b0;
        sh_load    = 1'b0;
        sh_shift   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                dout_oe = 1'b0;
                sh_load = cs_fall;
            end
            ST_ADDR:   sh_shift = sclk_fall;
            ST_SAMPLE: begin
                sample_en  = 1'b1;
                sh_shift   = sclk_fall;
                conv_start = sclk_fall && fall_cnt == LAST_SAMP_FALL;
            end
            ST_TAIL:   sh_shift = sclk_fall;
            ST_HOLD:   sh_shift = 1'b0;
            default:   dout_oe = 1'b0;
        endcase
    end

    sadc_shifter #(.RES_BITS(RES_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .shift    (sh_shift),
        .load_val (conv_result),
        .bit_out  (dout)
    );

    sadc_conv_stub #(
        .RES_BITS    (RES_BITS),
        .ADDR_BITS   (ADDR_BITS),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_conv (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (conv_start),
        .chan   (chan_sel),
        .busy   (conv_busy),
        .result (conv_result)
    );

    assign eoc = ~conv_busy;
endmodule

// File: rtl/sadc_front_chk.sv
module sadc_front_chk
    import sadc_pkg::*;
#(
    parameter int RES_BITS  = 10,
    parameter int ADDR_BITS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input xfer_state_t          state,
    input logic                 cs_s,
    input logic                 dout,
    input logic                 dout_oe,
    input logic                 eoc,
    input logic                 conv_start,
    input logic [RES_BITS-1:0]  conv_result,
    input logic [ADDR_BITS-1:0] chan_sel
);
    p_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !dout_oe);

    p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMPLE) |=> $stable(chan_sel));

    p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL || state == ST_HOLD) |-> !dout);

    p_eoc_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc) |-> $past(state) == ST_SAMPLE);

    p_result_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(conv_result) |-> $rose(eoc));

    p_start_only_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SAMPLE) |-> !conv_start);

    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (eoc || !$stable(state) || $past(!eoc)));
endmodule

bind sadc_front sadc_front_chk #(.RES_BITS(RES_BITS), .ADDR_BITS(ADDR_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .cs_s        (cs_s),
    .dout        (dout),
    .dout_oe     (dout_oe),
    .eoc         (eoc),
    .conv_start  (conv_start),
    .conv_result (conv_result),
    .chan_sel    (chan_sel)
);

// File: tb/sadc_front_test.sv
`timescale 1ns/1ps
module sadc_front_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       io_clk = 1'b0;
    logic       addr_in = 1'b0;
    logic       dout, dout_oe, eoc, sample_en;
    logic [3:0] chan_sel;

    int checks = 0;
    int failures = 0;
    int hh = 4;
    logic [9:0] prev_res = '0;

    always #2.5 clk = ~clk;

    sadc_front uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .io_clk    (io_clk),
        .addr_in   (addr_in),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .eoc       (eoc),
        .sample_en (sample_en),
        .chan_sel  (chan_sel)
    );

    function automatic logic [9:0] exp_res(input logic [3:0] a);
        return {a, 2'b10, ~a};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one transfer; release after n_clk clocks
    task automatic xfer(input logic [3:0] a, input int n_clk);
        logic [9:0] rd = prev_res;
        cs_n = 1'b0;
        cyc(hh);
        chk(dout_oe == 1'b1, "R2 oe", dout_oe, 1);
        chk(dout == rd[9], "R2 msb", dout, rd[9]);
        for (int k = 1; k <= n_clk; k++) begin
            addr_in = (k <= 4) ? a[4-k] : 1'($urandom);
            cyc(hh);
            io_clk = 1'b1;
            cyc(hh);
            if (k == 4) chk(chan_sel == a, "R3 chan", chan_sel, a);
            io_clk = 1'b0;
            cyc(hh);
            if (k <= 9) chk(dout == rd[9-k], "R4 bit", dout, rd[9-k]);
            else        chk(dout == 1'b0, "R5 zero", dout, 0);
            chk(sample_en == (k >= 4 && k < 10), "R6 window", sample_en, (k >= 4 && k < 10));
            if (k == 10) chk(eoc == 1'b0, "R7 eoc low", eoc, 0);
            if (k > 16)  chk(eoc == 1'b1, "R9 no restart", eoc, 1);
        end
        cs_n = 1'b1;
        cyc(hh);
        chk(dout_oe == 1'b0, "R1 hiz", dout_oe, 0);
        chk(sample_en == 1'b0, "R1 window off", sample_en, 0);
        if (n_clk >= 10) begin
            if (n_clk == 10) begin
                cyc(8);
                chk(eoc == 1'b0, "R7 still busy", eoc, 0);
            end
            cyc(30);
            chk(eoc == 1'b1, "R7 done", eoc, 1);
            chk(chan_sel == a, "R3 chan kept", chan_sel, a);
            prev_res = exp_res(a);
        end else begin
            cyc(30);
            chk(eoc == 1'b1, "R8 no conversion", eoc, 1);
        end
        cyc(4);
    endtask

    initial begin
        #(750_000);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd1543);
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk(eoc == 1'b1, "R10 eoc", eoc, 1);
        chk(dout_oe == 1'b0, "R10 oe", dout_oe, 0);
        chk(sample_en == 1'b0, "R10 window", sample_en, 0);

        // R1: serial clock activity while deselected
        for (int i = 0; i < 14; i++) begin
            addr_in = 1'($urandom);
            io_clk = ~io_clk;
            cyc(4);
        end
        io_clk = 1'b0;
        cyc(4);
        chk(eoc == 1'b1, "R1 no conversion", eoc, 1);
        chk(dout_oe == 1'b0, "R1 oe off", dout_oe, 0);

        // directed corners
        hh = 4; xfer(4'hA, 10);          // first read shows reset result 0
        hh = 4; xfer(4'h3, 16);
        hh = 5; xfer(4'hF, 7);           // R8 early release
        hh = 4; xfer(4'h0, 28);          // R9 long transfer
        hh = 6; xfer(4'h5, 3);           // R8 release during address phase
        hh = 4; xfer(4'h9, 20);

        for (int t = 0; t < 24; t++) begin
            int n;
            hh = 4 + int'($urandom_range(2, 0));
            n  = (t % 5 == 4) ? int'($urandom_range(9, 3)) : int'($urandom_range(16, 10));
            xfer(4'($urandom), n);
        end
        hh = 4; xfer(4'h0, 12);          // read out last result

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule